// File: doc/BRIEF.md
# Host Interrupt Request Pulse Shaper

This block is the interrupt control register of one host channel. It drives three request pins toward the host: a general interrupt (IRQ), a system-management interrupt (SMI) and a system-control interrupt (SCI). Each pin can come from one of two sources:

- a bit that firmware writes into the register, or
- hardware, derived from the channel's buffer status.

On the SMI hardware path a shaper turns output-buffer activity into one of two forms. It can be a level that tracks the output-buffer-full flag. It can instead be a single pulse of 1, 2, 4, 8 or 16 cycles on every write to the output buffer. SCI also has a one-shot source: firmware can arm it so that it fires once when the input-buffer-full flag drops.

Firmware reaches the block through a plain write strobe with a 9-bit data word and a combinational read word. The write port accepts a word in every cycle and never applies back-pressure, so it has no ready signal. The block has no streaming data path. The enhanced-mode enable, the three hardware-control enables and the buffer flags are plain level inputs. The buffer-write strobe is a one-cycle pulse. The block samples all of these inputs on the clock edge. Every pin reflects the state after the most recent edge.

The register layout is as follows:

| Bit(s) | Field |
|---|---|
| 0 | IRQ firmware bit |
| 1 | SMI firmware bit |
| 2 | SCI firmware bit |
| 3 | SMI invert |
| 4 | SCI invert |
| 7:5 | SMI shaper mode code |
| 8 | SCI arm, write-one |

Top module: `host_req_ctl`

## Requirements
- R1: While reset is asserted, and after it is released with no other activity, all three pins are 0 and `rd_data` reads 0. This is level mode with normal polarity.
- R2: With enhanced mode on and hardware control of a request off, a register write drives that request's pin from its firmware bit: bit 0 for IRQ, bit 1 for SMI, bit 2 for SCI. The pin shows the new value in the cycle after the write edge.
- R3: `rd_data` bits 2:0 return the current SCI, SMI and IRQ pin values in that order, whether or not hardware control is enabled. Bits 7:3 return the stored fields. Bit 8 always reads 0.
- R4: When register bit 3 is 1, the SMI pin is inverted, in both enhanced and legacy mode. When register bit 4 is 1, the SCI pin is inverted, in enhanced mode only.
- R5: With enhanced mode off, the IRQ and SCI pins equal the output-buffer-full flag sampled at the previous edge. The SMI pin equals that flag XOR bit 3. The firmware bits, hardware enables, mode code and arm writes have no effect.
- R6: With enhanced mode on and IRQ hardware control on, the IRQ pin equals the output-buffer-full flag sampled at the previous edge.
- R7: With SMI hardware control on and mode code 0, 6 or 7 (level), the SMI shaper output equals the output-buffer-full flag sampled at the previous edge. Buffer-write strobes do not affect it.
- R8: With SMI hardware control on and mode code 1, 2, 3, 4 or 5, each buffer-write strobe gives one high pulse of 1, 2, 4, 8 or 16 cycles respectively. The pulse starts in the cycle after the strobe edge. Between pulses the output rests at 0.
- R9: A buffer-write strobe that arrives while a pulse is active restarts the full width from that strobe, so the pulse stretches and does not overlap.
- R10: With enhanced mode on and SCI hardware control on, the SCI source is the output-buffer-full flag sampled at the previous edge.
- R11: Writing 1 to bit 8 in enhanced mode arms SCI. Writing 0 to bit 8 leaves the arm state unchanged. When the input-buffer-full flag changes from 1 to 0 while SCI is armed, the SCI source is ORed high for exactly one cycle and the arm is cleared. A later fall does not fire again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 9 | Register write word |
| rd_data | output | 9 | Register read word |
| enh_en | input | 1 | Enhanced mode enable |
| irq_hw_en | input | 1 | IRQ driven by hardware when 1 |
| smi_hw_en | input | 1 | SMI driven by shaper when 1 |
| sci_hw_en | input | 1 | SCI driven by hardware when 1 |
| obf | input | 1 | Output-buffer-full flag |
| ibf | input | 1 | Input-buffer-full flag |
| obuf_wr | input | 1 | Output-buffer write strobe |
| irq_pin | output | 1 | IRQ request pin |
| smi_pin | output | 1 | SMI request pin |
| sci_pin | output | 1 | SCI request pin |

## Verification
Directed cases set up each condition separately:

- Single strobes under every mode code measure the exact pulse width of each code. They also show that the reserved codes fall back to level tracking.
- Two strobes placed close together separate a restarted pulse from two distinct pulses.
- An arm, a write of zero and two falls of input-buffer-full separate one-shot firing from repeated firing or lost arming.
- Legacy-mode runs with the invert bits set show which polarity bit still applies.

A long seeded random run then mixes mode changes, enable flips, writes and buffer activity. It compares every pin and the read word in every cycle against a reference kept by the bench.

// File: rtl/host_req_pkg.sv
package host_req_pkg;
  localparam int NREQ      = 3;
  localparam int MODE_W    = 3;
  localparam int NUM_PULSE = 5;
  localparam int MAX_PULSE = 1 << (NUM_PULSE - 1);
  localparam int CNT_W     = $clog2(MAX_PULSE + 1);
  localparam int REG_W     = 9;
  localparam int B_ARM     = REG_W - 1;

  localparam int REQ_IRQ = 0;
  localparam int REQ_SMI = 1;
  localparam int REQ_SCI = 2;

  // Stored fields, packed so that the layout matches write-word bits 7:0.
  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic              sci_inv;
    logic              smi_inv;
    logic [NREQ-1:0]   fw;
  } ctl_t;

  // Pulse length for a mode code; 0 means level behaviour.
  function automatic logic [CNT_W-1:0] pulse_len(input logic [MODE_W-1:0] code);
    if (code >= MODE_W'(1) && code <= MODE_W'(NUM_PULSE))
      return CNT_W'(1) << (code - MODE_W'(1));
    return '0;
  endfunction

  function automatic logic is_pulse(input logic [MODE_W-1:0] code);
    return pulse_len(code) != '0;
  endfunction
endpackage

// File: rtl/host_req_regs.sv
module host_req_regs
  import host_req_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             enh_en,
  input  logic             ibf,
  output ctl_t             ctl,
  output logic             fire
);
  ctl_t ctl_q;
  logic arm_q;
  logic ibf_q;
  logic fire_q;
  logic ibf_fall;

  assign ibf_fall = ibf_q & ~ibf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      arm_q  <= 1'b0;
      ibf_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      ibf_q  <= ibf;
      fire_q <= arm_q & ibf_fall;
      if (wr_en)
        ctl_q <= ctl_t'(wr_data[B_ARM-1:0]);
      // A fresh arm write wins over the clear from a fire in the same cycle.
      if (wr_en && enh_en && wr_data[B_ARM])
        arm_q <= 1'b1;
      else if (arm_q && ibf_fall)
        arm_q <= 1'b0;
    end
  end

  assign ctl  = ctl_q;
  assign fire = fire_q;
endmodule

// File: rtl/host_req_shaper.sv
module host_req_shaper
  import host_req_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              strobe,
  input  logic              level_src,
  output logic              shaped
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (strobe)
      cnt_q <= pulse_len(mode);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CNT_W'(1);
  end

  assign shaped = is_pulse(mode) ? (cnt_q != '0) : level_src;
endmodule

// File: rtl/host_req_outmux.sv
module host_req_outmux
  import host_req_pkg::*;
(
  input  logic            enh,
  input  logic [NREQ-1:0] hw_en,
  input  logic [NREQ-1:0] fw,
  input  logic [NREQ-1:0] hw_src,
  input  logic [NREQ-1:0] extra,
  input  logic [NREQ-1:0] inv,
  input  logic [NREQ-1:0] leg_inv,
  input  logic            leg_src,
  output logic [NREQ-1:0] pin
);
  for (genvar i = 0; i < NREQ; i++) begin : g_req
    logic raw;
    assign raw    = (hw_en[i] ? hw_src[i] : fw[i]) | extra[i];
    assign pin[i] = enh ? (raw ^ inv[i]) : (leg_src ^ leg_inv[i]);
  end
endmodule

// File: rtl/host_req_ctl.sv
module host_req_ctl
  import host_req_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             enh_en,
  input  logic             irq_hw_en,
  input  logic             smi_hw_en,
  input  logic             sci_hw_en,
  input  logic             obf,
  input  logic             ibf,
  input  logic             obuf_wr,
  output logic             irq_pin,
  output logic             smi_pin,
  output logic             sci_pin
);
  ctl_t            ctl;
  logic            fire;
  logic            enh_q;
  logic            obf_q;
  logic [NREQ-1:0] hw_q;
  logic            shaped;
  logic [NREQ-1:0] hw_src;
  logic [NREQ-1:0] extra;
  logic [NREQ-1:0] inv;
  logic [NREQ-1:0] leg_inv;
  logic [NREQ-1:0] pins;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enh_q <= 1'b0;
      obf_q <= 1'b0;
      hw_q  <= '0;
    end else begin
      enh_q <= enh_en;
      obf_q <= obf;
      hw_q  <= {sci_hw_en, smi_hw_en, irq_hw_en};
    end
  end

  host_req_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .enh_en  (enh_en),
    .ibf     (ibf),
    .ctl     (ctl),
    .fire    (fire)
  );

  host_req_shaper u_shaper (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (ctl.mode),
    .strobe    (obuf_wr),
    .level_src (obf_q),
    .shaped    (shaped)
  );

  always_comb begin
    hw_src          = '0;
    extra           = '0;
    inv             = '0;
    leg_inv         = '0;
    hw_src[REQ_IRQ] = obf_q;
    hw_src[REQ_SMI] = shaped;
    hw_src[REQ_SCI] = obf_q;
    extra[REQ_SCI]  = fire;
    inv[REQ_SMI]    = ctl.smi_inv;
    inv[REQ_SCI]    = ctl.sci_inv;
    leg_inv[REQ_SMI] = ctl.smi_inv;
  end

  host_req_outmux u_mux (
    .enh     (enh_q),
    .hw_en   (hw_q),
    .fw      (ctl.fw),
    .hw_src  (hw_src),
    .extra   (extra),
    .inv     (inv),
    .leg_inv (leg_inv),
    .leg_src (obf_q),
    .pin     (pins)
  );

  assign irq_pin = pins[REQ_IRQ];
  assign smi_pin = pins[REQ_SMI];
  assign sci_pin = pins[REQ_SCI];
  assign rd_data = {1'b0, ctl.mode, ctl.sci_inv, ctl.smi_inv, pins};
endmodule

// File: rtl/host_req_ctl_chk.sv
module host_req_ctl_chk
  import host_req_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             enh_en,
  input logic             irq_hw_en,
  input logic             smi_hw_en,
  input logic             sci_hw_en,
  input logic             obf,
  input logic             obuf_wr,
  input logic             irq_pin,
  input logic             smi_pin,
  input logic             sci_pin
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (rd_data == '0 && !irq_pin && !smi_pin && !sci_pin));

  a_r2_fw_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en && !irq_hw_en && wr_en) |=> (irq_pin == $past(wr_data[0])));

  a_r4_smi_inv_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    (!enh_en && !wr_en) |=> (smi_pin == ($past(obf) ^ rd_data[3])));

  a_r5_legacy_level: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_en |=> (irq_pin == $past(obf) && sci_pin == $past(obf)));

  a_r6_irq_hw: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en && irq_hw_en) |=> (irq_pin == $past(obf)));

  a_r8_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en && smi_hw_en && obuf_wr && !wr_en && is_pulse(rd_data[7:5]))
      |=> (smi_pin != rd_data[3]));

  a_r10_sci_hw: assert property (@(posedge clk) disable iff (!rst_n)
    (enh_en && sci_hw_en && obf && !wr_en) |=> (sci_pin != rd_data[4]));
endmodule

bind host_req_ctl host_req_ctl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .enh_en    (enh_en),
  .irq_hw_en (irq_hw_en),
  .smi_hw_en (smi_hw_en),
  .sci_hw_en (sci_hw_en),
  .obf       (obf),
  .obuf_wr   (obuf_wr),
  .irq_pin   (irq_pin),
  .smi_pin   (smi_pin),
  .sci_pin   (sci_pin)
);

// File: tb/host_req_ctl_tb.sv
module host_req_ctl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [8:0] wr_data = '0;
  logic [8:0] rd_data;
  logic       enh_en = 1'b0;
  logic       irq_hw_en = 1'b0;
  logic       smi_hw_en = 1'b0;
  logic       sci_hw_en = 1'b0;
  logic       obf = 1'b0;
  logic       ibf = 1'b0;
  logic       obuf_wr = 1'b0;
  logic       irq_pin, smi_pin, sci_pin;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [2:0] m_fw = '0;
  logic       m_smi_inv = 0, m_sci_inv = 0, m_arm = 0, m_ibf_q = 0, m_fire = 0;
  logic       m_obf_q = 0, m_enh_q = 0;
  logic [2:0] m_mode = '0, m_hw_q = '0;
  int         m_rem = 0;

  always #4 clk = ~clk;

  host_req_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .enh_en(enh_en), .irq_hw_en(irq_hw_en), .smi_hw_en(smi_hw_en), .sci_hw_en(sci_hw_en),
    .obf(obf), .ibf(ibf), .obuf_wr(obuf_wr),
    .irq_pin(irq_pin), .smi_pin(smi_pin), .sci_pin(sci_pin)
  );

  function automatic int blen(input logic [2:0] c);
    if (c >= 3'd1 && c <= 3'd5) return 1 << (c - 1);
    return 0;
  endfunction

  function automatic logic [2:0] exp_pins();
    logic s_raw, c_raw, i_v;
    if (!m_enh_q) return {m_obf_q, m_obf_q ^ m_smi_inv, m_obf_q};
    i_v   = m_hw_q[0] ? m_obf_q : m_fw[0];
    s_raw = m_hw_q[1] ? ((blen(m_mode) != 0) ? (m_rem > 0) : m_obf_q) : m_fw[1];
    c_raw = (m_hw_q[2] ? m_obf_q : m_fw[2]) | m_fire;
    return {c_raw ^ m_sci_inv, s_raw ^ m_smi_inv, i_v};
  endfunction

  function automatic logic [8:0] exp_rd();
    return {1'b0, m_mode, m_sci_inv, m_smi_inv, exp_pins()};
  endfunction

  task automatic model_step();
    logic nfire;
    if (!rst_n) begin
      m_fw = '0; m_smi_inv = 0; m_sci_inv = 0; m_mode = '0; m_arm = 0;
      m_ibf_q = 0; m_fire = 0; m_obf_q = 0; m_enh_q = 0; m_hw_q = '0; m_rem = 0;
    end else begin
      nfire = m_arm && m_ibf_q && !ibf;
      if (wr_en && enh_en && wr_data[8]) m_arm = 1;
      else if (nfire) m_arm = 0;
      if (obuf_wr) m_rem = blen(m_mode);
      else if (m_rem > 0) m_rem = m_rem - 1;
      m_fire = nfire;
      if (wr_en) begin
        m_fw = wr_data[2:0]; m_smi_inv = wr_data[3];
        m_sci_inv = wr_data[4]; m_mode = wr_data[7:5];
      end
      m_ibf_q = ibf; m_obf_q = obf; m_enh_q = enh_en;
      m_hw_q = {sci_hw_en, smi_hw_en, irq_hw_en};
    end
  endtask

  task automatic chk(input string tag, input logic [8:0] act, input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all();
    logic [2:0] e;
    e = exp_pins();
    chk("R6 irq pin", {8'b0, irq_pin}, {8'b0, e[0]});
    chk("R8 smi pin", {8'b0, smi_pin}, {8'b0, e[1]});
    chk("R10 sci pin", {8'b0, sci_pin}, {8'b0, e[2]});
    chk("R3 read word", rd_data, exp_rd());
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmp_all();
  endtask

  task automatic wr(input logic [8:0] d);
    wr_en = 1; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic pulse_count(output int n);
    obuf_wr = 1;
    cyc();
    obuf_wr = 0;
    n = smi_pin ? 1 : 0;
    for (int k = 0; k < 24; k++) begin
      cyc();
      n += smi_pin ? 1 : 0;
    end
  endtask

  initial begin
    int n;
    void'($urandom(32'd4242));
    repeat (3) cyc();
    // R1 reset state
    chk("R1 pins in reset", {6'b0, irq_pin, smi_pin, sci_pin}, 9'd0);
    chk("R1 read in reset", rd_data, 9'd0);
    rst_n = 1;
    cyc();
    chk("R1 after release", {6'b0, irq_pin, smi_pin, sci_pin}, 9'd0);

    // R2 firmware bits drive pins
    enh_en = 1;
    cyc();
    wr(9'b0_000_00_101);
    chk("R2 fw irq", {8'b0, irq_pin}, 9'd1);
    chk("R2 fw smi", {8'b0, smi_pin}, 9'd0);
    chk("R2 fw sci", {8'b0, sci_pin}, 9'd1);

    // R3 arm bit reads 0, pins mirrored
    wr(9'b1_000_00_011);
    chk("R3 arm reads 0", {8'b0, rd_data[8]}, 9'd0);
    chk("R3 pin mirror", {6'b0, rd_data[2:0]}, {6'b0, sci_pin, smi_pin, irq_pin});
    ibf = 1; cyc(); ibf = 0; cyc(); cyc(); // consume the arm

    // R4 polarity
    wr(9'b0_000_11_000);
    chk("R4 smi inverted", {8'b0, smi_pin}, 9'd1);
    chk("R4 sci inverted", {8'b0, sci_pin}, 9'd1);
    enh_en = 0; obf = 0;
    cyc();
    chk("R4 smi inv legacy", {8'b0, smi_pin}, 9'd1);
    chk("R4 sci inv ignored legacy", {8'b0, sci_pin}, 9'd0);

    // R5 legacy follows obf only
    wr(9'b0_011_00_111);
    obf = 1; irq_hw_en = 1; smi_hw_en = 1;
    cyc();
    chk("R5 legacy irq", {8'b0, irq_pin}, 9'd1);
    chk("R5 legacy sci", {8'b0, sci_pin}, 9'd1);
    chk("R5 legacy smi", {8'b0, smi_pin}, 9'd1);
    obf = 0;
    cyc();
    chk("R5 legacy fw ignored", {6'b0, irq_pin, smi_pin, sci_pin}, 9'd0);
    irq_hw_en = 0; smi_hw_en = 0;

    // R6 irq hardware
    enh_en = 1; irq_hw_en = 1; wr(9'd0);
    obf = 1; cyc();
    chk("R6 irq follows obf hi", {8'b0, irq_pin}, 9'd1);
    obf = 0; cyc();
    chk("R6 irq follows obf lo", {8'b0, irq_pin}, 9'd0);

    // R7 level codes
    smi_hw_en = 1;
    foreach (n_codes[i]) begin
      wr({1'b0, n_codes[i], 5'b0});
      obf = 1; cyc();
      chk("R7 level high", {8'b0, smi_pin}, 9'd1);
      obf = 0; cyc();
      pulse_count(n);
      chk("R7 strobe ignored", n[8:0], 9'd0);
    end

    // R8 pulse widths
    for (int c = 1; c <= 5; c++) begin
      wr({1'b0, 3'(c), 5'b0});
      pulse_count(n);
      chk("R8 pulse width", n[8:0], 9'(1 << (c - 1)));
    end

    // R9 restart stretches
    wr({1'b0, 3'd3, 5'b0});
    obuf_wr = 1; cyc(); obuf_wr = 0;
    n = smi_pin ? 1 : 0;
    cyc(); n += smi_pin ? 1 : 0;
    obuf_wr = 1; cyc(); obuf_wr = 0; n += smi_pin ? 1 : 0;
    for (int k = 0; k < 20; k++) begin cyc(); n += smi_pin ? 1 : 0; end
    chk("R9 stretched width", n[8:0], 9'd6);

    // R10 sci hardware
    sci_hw_en = 1; obf = 1; cyc();
    chk("R10 sci from obf", {8'b0, sci_pin}, 9'd1);
    obf = 0; cyc();
    chk("R10 sci low", {8'b0, sci_pin}, 9'd0);
    sci_hw_en = 0;

    // R11 arm, zero write, single fire
    wr(9'd0);
    ibf = 1; cyc();
    wr(9'b1_000_00_000);
    wr(9'b0_000_00_000);
    ibf = 0; cyc();
    chk("R11 fire", {8'b0, sci_pin}, 9'd1);
    cyc();
    chk("R11 one cycle", {8'b0, sci_pin}, 9'd0);
    ibf = 1; cyc(); ibf = 0; cyc();
    chk("R11 no refire", {8'b0, sci_pin}, 9'd0);

    // random mix
    for (int t = 0; t < 4000; t++) begin
      wr_en     = ($urandom % 8) == 0;
      wr_data   = 9'($urandom);
      if (($urandom % 40) == 0) enh_en = ~enh_en;
      if (($urandom % 16) == 0) irq_hw_en = ~irq_hw_en;
      if (($urandom % 16) == 0) smi_hw_en = ~smi_hw_en;
      if (($urandom % 16) == 0) sci_hw_en = ~sci_hw_en;
      if (($urandom % 5) == 0) obf = ~obf;
      if (($urandom % 5) == 0) ibf = ~ibf;
      obuf_wr = ($urandom % 6) == 0;
      cyc();
    end
    wr_en = 0; obuf_wr = 0;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  logic [2:0] n_codes [3] = '{3'd0, 3'd6, 3'd7};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule